// File: doc/BRIEF.md
# Exact-Ratio Dual-Accumulator Phase Generator

This block is the phase engine of a direct digital synthesizer whose output frequency has to be an exact rational fraction of the clock. A wide binary phase register advances by a fixed tuning increment on every clock. On its own, that increment can only approximate the wanted frequency to within one least significant count. A small secondary stepper adds a fixed step on every clock, modulo a fixed modulus. Each time that stepper reaches or passes the modulus, it produces a carry. The carry goes into the phase adder as a carry-in in the same clock, so the phase register takes one extra count on that clock.

The secondary modulus sets the repeat period. The step sets how many extra counts go into the phase register over that period. After one full period, both registers are back at zero, and the long-term frequency equals the ratio that was designed in. The defaults give 32768 Hz from a 10 MHz clock: a 32-bit register with increment 14073748, and a stepper that adds 65276 modulo 78125. The phase register keeps a power-of-two modulus, so its top bits can address a downstream waveform table without change.

The outputs are the top phase bits, the phase MSB used as a square wave, and a one-clock pulse on each wrap of the phase register. All three are registered. The tuning constants are parameters, so the block has no data interface and needs no flow control.

Top module: `dual_acc_phase_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, both accumulators are cleared. After that edge, `phase_top` reads 0, `square_o` reads 0 and `wrap_o` reads 0.
- R2: On each clock edge out of reset, the secondary accumulator becomes (its old value + STEP) modulo MOD. A carry is raised on exactly those clocks where the old value + STEP is greater than or equal to MOD.
- R3: On each clock edge out of reset, the phase register becomes (old phase + TUNE + secondary carry of that same clock) modulo 2^PHASE_W. The carry goes in on the same clock, not one clock later.
- R4: `phase_top` equals the upper TOP_W bits of the phase register, and `square_o` equals its MSB.
- R5: `wrap_o` is high for exactly the one clock that follows an update in which the phase addition overflowed 2^PHASE_W. It is low at all other times.
- R6: With the default parameters, exactly 256 wraps occur in the 78125 clocks after reset.
- R7: After MOD clocks out of reset, both accumulators are back at zero. The phase sequence of the next period repeats the first one cycle for cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_top | output | TOP_W | Upper bits of the phase register |
| square_o | output | 1 | Phase MSB, a square wave at the synthesized frequency |
| wrap_o | output | 1 | One-clock pulse after each phase register wrap |

## Verification
The sharpest corner is the timing of the stepper carry. If the carry is added one clock late, the per-cycle phase drifts one count behind the model on every carry clock, while the long-run wrap count still looks right. A comparison every cycle therefore catches it at once. An off-by-one in the modulus compare (greater-than instead of greater-than-or-equal) breaks the exact 256-wraps-per-78125-clock count and leaves the phase nonzero at the period boundary. A wrap pulse taken from the wrong register stage shows up as a one-clock misalignment. A small second instance, with one wrap per 13 clocks, is hit with random mid-run resets to confirm that restarting always clears both accumulators.

// File: rtl/dap_pkg.sv
package dap_pkg;
  // width that holds any value of (acc + step) with acc < m and step < m
  function automatic int sum_width(longint unsigned m);
    return $clog2(2 * m);
  endfunction
endpackage

// File: rtl/mod_stepper.sv
module mod_stepper #(
  parameter longint unsigned MOD  = 78125,
  parameter longint unsigned STEP = 65276,
  parameter int W = dap_pkg::sum_width(MOD)
) (
  input  logic         clk,
  input  logic         rst,
  output logic         carry_o,
  output logic [W-1:0] acc_o
);
  localparam int WS = W + 1;
  localparam logic [W:0] STEP_V = WS'(STEP);
  localparam logic [W:0] MOD_V  = WS'(MOD);

  logic [W-1:0] acc_q;
  logic [W:0]   sum;
  logic [W:0]   folded;

  always_comb begin
    sum     = {1'b0, acc_q} + STEP_V;
    carry_o = (sum >= MOD_V);
    folded  = carry_o ? (sum - MOD_V) : sum;
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= folded[W-1:0];
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/bin_phase_acc.sv
module bin_phase_acc #(
  parameter int PHASE_W = 32,
  parameter longint unsigned TUNE = 14073748
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cin,
  output logic [PHASE_W-1:0] acc_o,
  output logic               cout_o
);
  localparam int PW1 = PHASE_W + 1;
  localparam logic [PHASE_W:0] TUNE_V = PW1'(TUNE);

  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W:0]   nxt;

  always_comb begin
    nxt    = {1'b0, acc_q} + TUNE_V + PW1'(cin);
    cout_o = nxt[PHASE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= nxt[PHASE_W-1:0];
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/phase_taps.sv
module phase_taps #(
  parameter int PHASE_W = 32,
  parameter int TOP_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] acc_i,
  input  logic               cout_i,
  output logic [TOP_W-1:0]   top_o,
  output logic               sq_o,
  output logic               wrap_o
);
  logic wrap_q;

  always_ff @(posedge clk) begin
    if (rst) wrap_q <= 1'b0;
    else     wrap_q <= cout_i;
  end

  assign top_o  = acc_i[PHASE_W-1 -: TOP_W];
  assign sq_o   = acc_i[PHASE_W-1];
  assign wrap_o = wrap_q;
endmodule

// File: rtl/dual_acc_phase_gen.sv
module dual_acc_phase_gen #(
  parameter int PHASE_W = 32,
  parameter int TOP_W   = 8,
  parameter longint unsigned TUNE = 14073748,
  parameter longint unsigned STEP = 65276,
  parameter longint unsigned MOD  = 78125
) (
  input  logic             clk,
  input  logic             rst,
  output logic [TOP_W-1:0] phase_top,
  output logic             square_o,
  output logic             wrap_o
);
  localparam int SW = dap_pkg::sum_width(MOD);

  logic               sec_carry;
  logic [SW-1:0]      sec_q;
  logic [PHASE_W-1:0] prim_q;
  logic               prim_cout;

  mod_stepper #(.MOD(MOD), .STEP(STEP), .W(SW)) u_sec (
    .clk(clk), .rst(rst), .carry_o(sec_carry), .acc_o(sec_q)
  );

  bin_phase_acc #(.PHASE_W(PHASE_W), .TUNE(TUNE)) u_prim (
    .clk(clk), .rst(rst), .cin(sec_carry), .acc_o(prim_q), .cout_o(prim_cout)
  );

  phase_taps #(.PHASE_W(PHASE_W), .TOP_W(TOP_W)) u_taps (
    .clk(clk), .rst(rst), .acc_i(prim_q), .cout_i(prim_cout),
    .top_o(phase_top), .sq_o(square_o), .wrap_o(wrap_o)
  );
endmodule

// File: rtl/dap_checker.sv
module dap_checker #(
  parameter int PHASE_W = 32,
  parameter int TOP_W   = 8,
  parameter longint unsigned TUNE = 14073748,
  parameter longint unsigned STEP = 65276,
  parameter longint unsigned MOD  = 78125,
  parameter int SW = 18
) (
  input logic               clk,
  input logic               rst,
  input logic [PHASE_W-1:0] prim,
  input logic [SW-1:0]      sec,
  input logic               carry,
  input logic [TOP_W-1:0]   top,
  input logic               wrap
);
  localparam longint unsigned PMOD = 64'd1 << PHASE_W;

  // R1: reset clears the outputs on the next cycle
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (top == '0 && wrap == 1'b0));

  // R2: secondary stays below its modulus
  a_r2_sec_range: assert property (@(posedge clk) disable iff (rst)
    64'(sec) < MOD);

  // R2: secondary step modulo MOD
  a_r2_sec_step: assert property (@(posedge clk) disable iff (rst)
    !rst |=> 64'(sec) == (64'($past(sec)) + STEP) % MOD);

  // R3: same-cycle carry-in on the phase register
  a_r3_phase_step: assert property (@(posedge clk) disable iff (rst)
    !rst |=> 64'(prim) == (64'($past(prim)) + TUNE + 64'($past(carry))) % PMOD);

  // R5: wrap flags exactly the updates that went backwards
  a_r5_wrap_match: assert property (@(posedge clk) disable iff (rst)
    !rst |=> wrap == (prim < $past(prim)));
endmodule

bind dual_acc_phase_gen dap_checker #(
  .PHASE_W(PHASE_W), .TOP_W(TOP_W), .TUNE(TUNE), .STEP(STEP), .MOD(MOD), .SW(SW)
) u_chk (
  .clk(clk), .rst(rst), .prim(prim_q), .sec(sec_q), .carry(sec_carry),
  .top(phase_top), .wrap(wrap_o)
);

// File: tb/dual_acc_phase_gen_test.sv
module dual_acc_phase_gen_test;
  localparam int CLK_PERIOD = 10;
  // small instance: 13*19 + 9 = 256 -> one wrap per 13 clocks
  localparam int S_PW = 8, S_TW = 3;
  localparam longint unsigned S_TUNE = 19, S_STEP = 9, S_MOD = 13;
  localparam longint unsigned D_TUNE = 14073748, D_STEP = 65276, D_MOD = 78125;

  logic clk = 1'b0;
  logic rst_a = 1'b1, rst_b = 1'b1;
  logic [7:0] top_a; logic sq_a, wr_a;
  logic [S_TW-1:0] top_b; logic sq_b, wr_b;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_acc_phase_gen uut (.clk(clk), .rst(rst_a), .phase_top(top_a), .square_o(sq_a), .wrap_o(wr_a));
  dual_acc_phase_gen #(.PHASE_W(S_PW), .TOP_W(S_TW), .TUNE(S_TUNE), .STEP(S_STEP), .MOD(S_MOD))
    uut_small (.clk(clk), .rst(rst_b), .phase_top(top_b), .square_o(sq_b), .wrap_o(wr_b));

  // reference state
  longint unsigned ma_p, ma_s, mb_p, mb_s;
  bit ma_w, mb_w;

  function automatic longint unsigned sec_next(longint unsigned s, longint unsigned st, longint unsigned m);
    return (s + st) % m;
  endfunction
  function automatic bit sec_cy(longint unsigned s, longint unsigned st, longint unsigned m);
    return (s + st) >= m;
  endfunction

  task automatic check(bit ok, string req, longint unsigned act, longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    longint unsigned p;
    bit c;
    @(posedge clk);
    if (rst_a) begin ma_p = 0; ma_s = 0; ma_w = 0; end
    else begin
      c = sec_cy(ma_s, D_STEP, D_MOD); ma_s = sec_next(ma_s, D_STEP, D_MOD);
      p = ma_p + D_TUNE + 64'(c); ma_w = p[32]; ma_p = p & 64'hFFFF_FFFF;
    end
    if (rst_b) begin mb_p = 0; mb_s = 0; mb_w = 0; end
    else begin
      c = sec_cy(mb_s, S_STEP, S_MOD); mb_s = sec_next(mb_s, S_STEP, S_MOD);
      p = mb_p + S_TUNE + 64'(c); mb_w = p[8]; mb_p = p & 64'hFF;
    end
    @(negedge clk);
  endtask

  // per-cycle comparison (R2 R3 R4 R5 all feed the phase)
  task automatic cmp_all();
    check(top_a == 8'(ma_p >> 24), "R3 phase_top", top_a, ma_p >> 24);
    check(sq_a == ma_p[31], "R4 square", sq_a, ma_p[31]);
    check(wr_a == ma_w, "R5 wrap", wr_a, ma_w);
    check(top_b == S_TW'(mb_p >> 5), "R2 small phase_top", top_b, mb_p >> 5);
    check(sq_b == mb_p[7], "R4 small square", sq_b, mb_p[7]);
    check(wr_b == mb_w, "R5 small wrap", wr_b, mb_w);
  endtask

  logic [7:0] first_top [500];
  int wraps;

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    // R1 reset state
    check(top_a == 0 && sq_a == 0 && wr_a == 0, "R1 reset", {top_a, sq_a, wr_a}, 0);
    check(top_b == 0 && sq_b == 0 && wr_b == 0, "R1 small reset", {top_b, sq_b, wr_b}, 0);
    rst_a = 1'b0;
    wraps = 0;
    for (int i = 0; i < 78125; i++) begin
      tick();
      cmp_all();
      if (wr_a) wraps++;
      if (i < 500) first_top[i] = top_a;
    end
    check(wraps == 256, "R6 wrap count", wraps, 256);
    check(top_a == 0 && sq_a == 0, "R7 phase zero at period", top_a, 0);
    check(ma_s == 0 && ma_p == 0, "R7 model zero at period", ma_s + ma_p, 0);
    for (int i = 0; i < 500; i++) begin
      tick();
      cmp_all();
      check(top_a == first_top[i], "R7 repeat", top_a, first_top[i]);
    end
    // random resets on the small instance
    rst_b = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      tick();
      cmp_all();
      if (rst_b) check(top_b == 0 && wr_b == 0, "R1 small mid reset", {top_b, wr_b}, 0);
      rst_b = ($urandom_range(0, 99) < 3);
    end
    // directed: reset the small one, then check one wrap per 13 clocks
    rst_b = 1'b1; tick(); rst_b = 1'b0;
    wraps = 0;
    for (int i = 0; i < 13 * 4; i++) begin
      tick(); cmp_all(); if (wr_b) wraps++;
    end
    check(wraps == 4, "R6 small wrap count", wraps, 4);
    check(top_b == 0, "R7 small phase zero", top_b, 0);
    // reset of the default instance mid-stream
    rst_a = 1'b1; tick();
    check(top_a == 0 && wr_a == 0, "R1 mid reset", {top_a, wr_a}, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule